// File: doc/BRIEF.md
# ATM Transmit Cell Buffer

This block sits between a byte-wide cell source and a cell-insertion stage. Cells arrive one byte per clock through a write port with an active-low enable and a start-of-cell marker, and they are kept in a circular store that holds exactly three 53-byte cells. A cell is only counted as ready once all 53 of its bytes are in. The store reports when it is close to full, and a sticky flag records any byte it had to drop.

The insertion stage asks for a cell by pulsing `slot_start`. If a complete cell is waiting, its 53 bytes come out in write order, one per clock. If not, the block makes up a filler cell instead. A control input picks the filler: an idle cell or an unassigned cell. Every emitted cell carries a start strobe on its first byte. Writing and reading share a single clock.

Top module: `atm_tx_cell_buf`

## Requirements
- R1: A byte is taken on a rising clock edge only while `wr_en_n` is low. With `wr_en_n` high, the data and marker inputs have no effect.
- R2: A byte taken with `wr_soc` high opens a new cell and is stored as its byte 0. A byte taken with `wr_soc` low while no cell is open is discarded and does not occupy space.
- R3: The store holds up to 159 bytes, counting partial cells and bytes not yet emitted. `almost_full` is high exactly while 154 or more bytes are held.
- R4: `cell_ready` is high while at least one complete cell is stored and not yet claimed. A cell becomes eligible on the edge that takes its 53rd byte, so a slot sampled on that same edge does not see it.
- R5: A slot that begins while a complete cell is stored emits that cell's 53 bytes in write order. Byte 0 appears after the edge that samples `slot_start`, and one further byte follows per clock.
- R6: A slot that begins with no complete cell stored emits a filler cell. `fill_sel` is sampled at slot start. With 0 the header is 00 00 00 01 52 (hex). With 1 it is 00 00 00 00 55 (hex). In both cases the 48 payload bytes are 6A (hex).
- R7: `out_valid` is high for exactly the 53 cycles of an emitted cell. `out_soc` is high only with byte 0 of each cell, stored or filler. `out_data` is 00 whenever `out_valid` is low.
- R8: `slot_start` is ignored while a cell is being emitted, except during its last byte. A pulse during the last byte starts the next cell with no gap.
- R9: A byte with `wr_soc` high that arrives while a cell is open and incomplete discards the partial cell and frees its space before the new byte is stored.
- R10: A byte offered while 159 bytes are held is dropped and `overflow` goes high until reset. If the dropped byte belonged to an open cell, that partial cell is discarded as well.
- R11: While `rst_n` is low the store is empty, no cell is open, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write and read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low byte write enable |
| wr_soc | input | 1 | Marks the first byte of an incoming cell |
| wr_data | input | 8 | Incoming cell byte |
| fill_sel | input | 1 | Filler choice: 0 idle, 1 unassigned |
| slot_start | input | 1 | Insertion stage requests the next cell |
| cell_ready | output | 1 | A complete cell is waiting |
| almost_full | output | 1 | Five or fewer free bytes remain |
| overflow | output | 1 | Sticky: a byte was dropped for lack of space |
| out_valid | output | 1 | A cell byte is on `out_data` |
| out_soc | output | 1 | First byte of an emitted cell |
| out_data | output | 8 | Emitted cell byte |

## Verification
The hardest state to reach is a full store whose write pointer has wrapped past the end of the array. It must also have a partial cell being thrown away while a stored cell is being read out in the same cycles. Directed steps first fill the store to exactly 154 and 159 bytes, then force an overflow, then drain it. After that, a long random phase runs with frequent markers, dense writes and back-to-back slots, which drives the pointers around the ring many times with reads and writes overlapping. A behavioural queue model is compared against every output on every clock.

// File: rtl/atm_txbuf_pkg.sv
package atm_txbuf_pkg;

    localparam int CELL_BYTES = 53;
    localparam int IW         = $clog2(CELL_BYTES);

    // Byte of a filler cell at position idx; unassigned selects the variant.
    function automatic logic [7:0] filler_byte(input logic unassigned,
                                               input logic [IW-1:0] idx);
        logic [7:0] b;
        if (idx < IW'(3))       b = 8'h00;
        else if (idx == IW'(3)) b = unassigned ? 8'h00 : 8'h01;
        else if (idx == IW'(4)) b = unassigned ? 8'h55 : 8'h52;
        else                    b = 8'h6A;
        return b;
    endfunction

endpackage

// File: rtl/txbuf_mem.sv
module txbuf_mem #(
    parameter int DEPTH = 159,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/txbuf_wr_ctrl.sv
module txbuf_wr_ctrl
    import atm_txbuf_pkg::*;
#(
    parameter int DEPTH = 159,
    parameter int PW    = 8,
    parameter int CNTW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            wr_soc,
    input  logic [CNTW-1:0] used_q,
    output logic            mem_we,
    output logic [PW-1:0]   mem_waddr,
    output logic            acc,
    output logic [IW-1:0]   disc,
    output logic            commit,
    output logic            ovf_evt
);
    typedef struct packed {
        logic          open;
        logic [IW-1:0] part;
        logic [PW-1:0] wptr;
        logic [PW-1:0] start;
    } wr_st_t;

    wr_st_t st_d, st_q;

    function automatic logic [PW-1:0] ring_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_waddr = st_q.wptr;
        acc       = 1'b0;
        disc      = '0;
        commit    = 1'b0;
        ovf_evt   = 1'b0;
        if (wr_stb) begin
            if (wr_soc) begin
                disc = st_q.open ? st_q.part : '0;
                if ((used_q - CNTW'(disc)) < CNTW'(DEPTH)) begin
                    mem_we     = 1'b1;
                    mem_waddr  = st_q.start;
                    acc        = 1'b1;
                    st_d.open  = 1'b1;
                    st_d.part  = IW'(1);
                    st_d.wptr  = ring_inc(st_q.start);
                end else begin
                    ovf_evt    = 1'b1;
                    st_d.open  = 1'b0;
                    st_d.part  = '0;
                    st_d.wptr  = st_q.start;
                end
            end else if (st_q.open) begin
                if (used_q < CNTW'(DEPTH)) begin
                    mem_we    = 1'b1;
                    acc       = 1'b1;
                    st_d.wptr = ring_inc(st_q.wptr);
                    if (st_q.part == IW'(CELL_BYTES - 1)) begin
                        commit     = 1'b1;
                        st_d.open  = 1'b0;
                        st_d.part  = '0;
                        st_d.start = ring_inc(st_q.wptr);
                    end else begin
                        st_d.part  = st_q.part + IW'(1);
                    end
                end else begin
                    ovf_evt   = 1'b1;
                    disc      = st_q.part;
                    st_d.open = 1'b0;
                    st_d.part = '0;
                    st_d.wptr = st_q.start;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: with no cell open the write pointer rests on the next cell start
    a_r2_closed_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.open |-> (st_q.wptr == st_q.start));

    // R9: a partial cell never reaches full length without being committed
    a_r9_part_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.part < IW'(CELL_BYTES));

endmodule

// File: rtl/txbuf_rd_ctrl.sv
module txbuf_rd_ctrl
    import atm_txbuf_pkg::*;
#(
    parameter int DEPTH = 159,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_start,
    input  logic          fill_sel,
    input  logic          cells_avail,
    input  logic [7:0]    mem_rdata,
    output logic [PW-1:0] rptr,
    output logic          pop,
    output logic          claim,
    output logic          out_valid,
    output logic          out_soc,
    output logic [7:0]    out_data
);
    localparam logic [IW-1:0] LAST = IW'(CELL_BYTES - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic          stored;
        logic          fsel;
        logic [PW-1:0] rptr;
        logic          out_valid;
        logic          out_soc;
        logic [7:0]    out_data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   begin_slot;

    function automatic logic [PW-1:0] ring_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d       = st_q;
        pop        = 1'b0;
        claim      = 1'b0;
        begin_slot = slot_start && (!st_q.busy || st_q.idx == LAST);
        if (begin_slot) begin
            st_d.busy      = 1'b1;
            st_d.idx       = '0;
            st_d.stored    = cells_avail;
            st_d.fsel      = fill_sel;
            st_d.out_valid = 1'b1;
            st_d.out_soc   = 1'b1;
            claim          = cells_avail;
            if (cells_avail) begin
                pop           = 1'b1;
                st_d.out_data = mem_rdata;
                st_d.rptr     = ring_inc(st_q.rptr);
            end else begin
                st_d.out_data = filler_byte(fill_sel, '0);
            end
        end else if (st_q.busy && st_q.idx != LAST) begin
            st_d.idx     = st_q.idx + IW'(1);
            st_d.out_soc = 1'b0;
            if (st_q.stored) begin
                pop           = 1'b1;
                st_d.out_data = mem_rdata;
                st_d.rptr     = ring_inc(st_q.rptr);
            end else begin
                st_d.out_data = filler_byte(st_q.fsel, st_q.idx + IW'(1));
            end
        end else begin
            st_d.busy      = 1'b0;
            st_d.out_valid = 1'b0;
            st_d.out_soc   = 1'b0;
            st_d.out_data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rptr      = st_q.rptr;
    assign out_valid = st_q.out_valid;
    assign out_soc   = st_q.out_soc;
    assign out_data  = st_q.out_data;

    // R7: the start strobe only accompanies a valid byte
    a_r7_soc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    // R7: idle output carries zero data
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == 8'h00));

    // R8: a request in the middle of a cell does not restart it
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.idx != LAST && slot_start) |=> !out_soc);

endmodule

// File: rtl/atm_tx_cell_buf.sv
module atm_tx_cell_buf
    import atm_txbuf_pkg::*;
#(
    parameter int CELLS     = 3,
    parameter int AF_MARGIN = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_n,
    input  logic       wr_soc,
    input  logic [7:0] wr_data,
    input  logic       fill_sel,
    input  logic       slot_start,
    output logic       cell_ready,
    output logic       almost_full,
    output logic       overflow,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);
    localparam int DEPTH = CELLS * CELL_BYTES;
    localparam int PW    = $clog2(DEPTH);
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int CW    = $clog2(CELLS + 1);

    typedef struct packed {
        logic [CNTW-1:0] used;
        logic [CW-1:0]   cells;
        logic            ovf;
    } occ_st_t;

    occ_st_t st_d, st_q;

    logic          mem_we;
    logic [PW-1:0] mem_waddr;
    logic [PW-1:0] mem_raddr;
    logic [7:0]    mem_rdata;
    logic          acc, commit, ovf_evt, pop, claim;
    logic [IW-1:0] disc;

    txbuf_mem #(.DEPTH(DEPTH), .AW(PW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    txbuf_wr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CNTW(CNTW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (!wr_en_n),
        .wr_soc    (wr_soc),
        .used_q    (st_q.used),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .acc       (acc),
        .disc      (disc),
        .commit    (commit),
        .ovf_evt   (ovf_evt)
    );

    txbuf_rd_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_start  (slot_start),
        .fill_sel    (fill_sel),
        .cells_avail (st_q.cells != '0),
        .mem_rdata   (mem_rdata),
        .rptr        (mem_raddr),
        .pop         (pop),
        .claim       (claim),
        .out_valid   (out_valid),
        .out_soc     (out_soc),
        .out_data    (out_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.used  = st_q.used + CNTW'(acc) - CNTW'(pop) - CNTW'(disc);
        st_d.cells = st_q.cells + CW'(commit) - CW'(claim);
        st_d.ovf   = st_q.ovf | ovf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cell_ready  = (st_q.cells != '0);
    assign almost_full = (st_q.used >= CNTW'(DEPTH - AF_MARGIN));
    assign overflow    = st_q.ovf;

    // R3: occupancy never exceeds capacity
    a_r3_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= CNTW'(DEPTH));

    // R4: complete cells always fit inside the bytes held
    a_r4_cells_fit: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.cells) * CELL_BYTES) <= 32'(st_q.used));

    // R5: a byte is read out only when something is held
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.used != '0));

    // R10: the overflow flag is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: tb/atm_tx_cell_buf_tb_top.sv
module atm_tx_cell_buf_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       wr_soc = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fill_sel = 1'b0;
    logic       slot_start = 1'b0;
    logic       cell_ready, almost_full, overflow, out_valid, out_soc;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    atm_tx_cell_buf dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_soc(wr_soc),
        .wr_data(wr_data), .fill_sel(fill_sel), .slot_start(slot_start),
        .cell_ready(cell_ready), .almost_full(almost_full), .overflow(overflow),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_done[$];
    logic [7:0] m_part[$];
    bit m_open, m_ovf, m_busy, m_stored, m_fsel;
    int m_cells, m_idx;
    bit e_valid, e_soc;
    logic [7:0] e_data;

    function automatic logic [7:0] ref_filler(bit unas, int k);
        case (k)
            0, 1, 2: return 8'h00;
            3:       return unas ? 8'h00 : 8'h01;
            4:       return unas ? 8'h55 : 8'h52;
            default: return 8'h6A;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_done.delete(); m_part.delete();
            m_open = 0; m_ovf = 0; m_busy = 0; m_stored = 0; m_fsel = 0;
            m_cells = 0; m_idx = 0; e_valid = 0; e_soc = 0; e_data = 0;
        end else begin
            int u0, c0;
            u0 = m_done.size() + m_part.size();
            c0 = m_cells;
            // read side
            if (slot_start && (!m_busy || m_idx == 52)) begin
                m_busy = 1; m_idx = 0; m_stored = (c0 > 0); m_fsel = fill_sel;
                if (m_stored) m_cells--;
                e_valid = 1; e_soc = 1;
                e_data = m_stored ? m_done.pop_front() : ref_filler(fill_sel, 0);
            end else if (m_busy && m_idx < 52) begin
                m_idx++; e_soc = 0;
                e_data = m_stored ? m_done.pop_front() : ref_filler(m_fsel, m_idx);
            end else begin
                m_busy = 0; e_valid = 0; e_soc = 0; e_data = 0;
            end
            // write side
            if (!wr_en_n) begin
                if (wr_soc) begin
                    int drop;
                    drop = m_part.size();
                    m_part.delete();
                    if (u0 - drop < 159) begin
                        m_part.push_back(wr_data); m_open = 1;
                    end else begin
                        m_ovf = 1; m_open = 0;
                    end
                end else if (m_open) begin
                    if (u0 < 159) begin
                        m_part.push_back(wr_data);
                        if (m_part.size() == 53) begin
                            foreach (m_part[i]) m_done.push_back(m_part[i]);
                            m_part.delete(); m_open = 0; m_cells++;
                        end
                    end else begin
                        m_ovf = 1; m_part.delete(); m_open = 0;
                    end
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 out_valid", out_valid, e_valid);
            check("R7 out_soc", out_soc, e_soc);
            check(m_stored ? "R5 out_data" : "R6 out_data", out_data, e_data);
            check("R4 cell_ready", cell_ready, m_cells > 0);
            check("R3 almost_full", almost_full,
                  (m_done.size() + m_part.size()) >= 154);
            check("R10 overflow", overflow, m_ovf);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en_n = 1; wr_soc = 0; slot_start = 0;
        end
    endtask

    task automatic wbytes(input int n, input bit soc_first, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en_n = 0; wr_soc = soc_first && (i == 0);
            wr_data = base + 8'(i); slot_start = 0;
        end
    endtask

    task automatic slot(input bit sel);
        @(negedge clk);
        wr_en_n = 1; wr_soc = 0; slot_start = 1; fill_sel = sel;
    endtask

    // ---------------- sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset cell_ready", cell_ready, 0);
        check("R11 reset almost_full", almost_full, 0);
        check("R11 reset overflow", overflow, 0);
        check("R11 reset out_valid", out_valid, 0);
        check("R11 reset out_data", out_data, 0);
        rst_n = 1;
        idle(2);

        // R1: writes with enable high leave the store untouched
        for (int i = 0; i < 160; i++) begin
            @(negedge clk); wr_en_n = 1; wr_soc = (i % 53 == 0); wr_data = 8'(i);
        end
        idle(1);
        check("R1 no capture af", almost_full, 0);
        check("R1 no capture ready", cell_ready, 0);

        // R2: bytes with no open cell are dropped
        wbytes(160, 0, 8'h10);
        idle(1);
        check("R2 stray af", almost_full, 0);
        check("R2 stray ovf", overflow, 0);

        // R6: filler cells of both kinds
        slot(0); idle(60);
        slot(1); idle(60);

        // R4: eligibility on the 53rd byte
        wbytes(52, 1, 8'h20);
        idle(1);
        check("R4 partial not ready", cell_ready, 0);
        wbytes(1, 0, 8'h54);
        idle(1);
        check("R4 complete ready", cell_ready, 1);
        slot(0); idle(1);
        check("R5 first stored byte", out_data, 8'h20);
        idle(60);

        // R9: restart discards the partial cell and its space
        wbytes(30, 1, 8'h40);
        wbytes(53, 1, 8'h80);
        wbytes(53, 1, 8'h90);
        wbytes(53, 1, 8'hA0);
        idle(1);
        check("R9 space freed", overflow, 0);
        check("R9 three cells af", almost_full, 1);
        slot(0); idle(1);
        check("R9 new cell first byte", out_data, 8'h80);
        idle(60);
        slot(0); idle(60);
        slot(0); idle(60);

        // R3: threshold at 154 bytes
        wbytes(53, 1, 8'h01);
        wbytes(53, 1, 8'h02);
        wbytes(47, 1, 8'h03);
        idle(1);
        check("R3 153 bytes", almost_full, 0);
        wbytes(1, 0, 8'h33);
        idle(1);
        check("R3 154 bytes", almost_full, 1);
        wbytes(5, 0, 8'h34);
        idle(1);
        check("R3 full ready", cell_ready, 1);

        // R10: overflow when full
        wbytes(1, 1, 8'hEE);
        idle(3);
        check("R10 overflow set", overflow, 1);

        // R8: mid-cell request ignored, last-byte request chains
        slot(0); idle(10);
        slot(0); idle(41);
        slot(0);
        @(negedge clk); slot_start = 0;
        check("R8 chained soc", out_soc, 1);
        idle(60);
        check("R8 idle after cell", out_valid, 0);
        check("R10 still set", overflow, 1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            wr_en_n    = ($urandom % 10) >= 7;
            wr_soc     = ($urandom % 45) == 0;
            wr_data    = 8'($urandom);
            slot_start = ($urandom % 25) == 0;
            fill_sel   = 1'($urandom);
        end
        idle(200);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule